// File: doc/BRIEF.md
# Compare-Value Timer with Signed Downcounter View

This block keeps one 64-bit compare value for a secure physical timer and checks it against a free-running 64-bit system count supplied from outside. Software does not have to handle the 64-bit compare value directly. It can use a 32-bit relative view instead, which makes the timer behave like a downcounter. Writing the view sets the compare value to the current count plus a signed 32-bit amount. Reading the view returns how far the compare value still lies ahead of the count.

Every register access goes through a privilege and security checker first. The checker approves the access, rejects it as undefined, or sends it as a trap with a fixed class to the highest privilege level. At privilege level 1, when four configuration bits are all set, an external virtualisation offset is taken off the count in both directions.

The block registers a timer-condition output. This output is raised when the timer is enabled and the count has reached or passed the compare value.

Top module: `sec_cmp_timer`

## Requirements
- R1: An approved write sets the compare value to the count plus the sign-extended bits 31:0 of `req_wdata_i`. Bits 63:32 of the write data have no effect.
- R2: An approved read while enabled returns the compare value minus the count, modulo 2^64. An approved read while disabled returns 0.
- R3: At each clock edge, `cond_o` is loaded with 1 when the enable is 1 and bit 63 of (count − compare value) is 0. Otherwise it is loaded with 0. The output therefore lags the count and the compare value by one cycle.
- R4: Some level-1 accesses take the offset path. This happens when `off_impl_i`, `el2_on_i`, `off_en3_i` and `off_en2_i` are all 1. On that path a write stores signext(data) + count − offset, and a read returns compare − (count − offset). Level-3 accesses never take this path.
- R5: Outcome encoding: 2'b00 approved, 2'b01 undefined, 2'b10 trap. The outcome is undefined when any of these holds:
  - the selector `{op0,op1,CRn,CRm,op2}` is not 16'hFF10;
  - the level is 0;
  - the level is 2.

  A level-3 access with the matching selector is approved. With no request, the outcome is 2'b00.
- R6: At level 1, the outcome is undefined in three cases: `el3_present_i` is 0, `ns_i` is 1, or `sel2_en_i` is 1.
- R7: At level 1, if none of the R6 conditions holds and `st_access_i` is 0, the outcome is trap and `trap_class_o` is 6'h18. For any other outcome, `trap_class_o` is 0.
- R8: When the outcome is not approved, the compare value is not changed and `rdata_o` is 0. `rdata_o` is also 0 for any access that is not a read.
- R9: After reset, the compare value is 0, the enable is 0 and `cond_o` is 0.
- R10: `ena_we_i` loads `ena_i` into the enable at the next clock edge. This is independent of any register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 64 | Free-running system count |
| offset_i | input | 64 | Virtualisation offset |
| el3_present_i | input | 1 | Level 3 is implemented |
| ns_i | input | 1 | Non-secure state bit |
| sel2_en_i | input | 1 | Secure level-2 enable |
| st_access_i | input | 1 | Level 1 may access the secure timer |
| off_impl_i | input | 1 | Offset feature implemented |
| el2_on_i | input | 1 | Level 2 enabled |
| off_en3_i | input | 1 | Level-3 control for the offset |
| off_en2_i | input | 1 | Level-2 control for the offset |
| ena_we_i | input | 1 | Load the timer enable |
| ena_i | input | 1 | New timer enable value |
| req_valid_i | input | 1 | Register access present |
| req_write_i | input | 1 | Access is a write |
| req_el_i | input | 2 | Privilege level of the access |
| req_sel_i | input | 16 | Register selector {op0,op1,CRn,CRm,op2} |
| req_wdata_i | input | 64 | Write data |
| outcome_o | output | 2 | Access outcome |
| trap_class_o | output | 6 | Trap class |
| rdata_o | output | 64 | Read data |
| cond_o | output | 1 | Registered timer condition |

## Verification
The assertions assume three things about the inputs:
- the count, the offset and the configuration bits are stable around the clock edge;
- every request is decided within its own cycle;
- the request fields are never X while `req_valid_i` is 1.

The bench drives every input on the falling edge and holds it for a full cycle. The count moves only between cycles, in small steps or occasional large jumps, including across the 64-bit wrap. The configuration bits are drawn so that every access outcome appears often, and an all-levels sweep covers every combination of level, security and access bits.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [1:0] {
    OUT_OK    = 2'b00,
    OUT_UNDEF = 2'b01,
    OUT_TRAP  = 2'b10
  } outcome_e;

  localparam logic [1:0] LVL0 = 2'd0;
  localparam logic [1:0] LVL1 = 2'd1;
  localparam logic [1:0] LVL2 = 2'd2;
  localparam logic [1:0] LVL3 = 2'd3;
endpackage

// File: rtl/sct_access_chk.sv
module sct_access_chk
  import sct_pkg::*;
#(
  parameter int              SEL_W    = 16,
  parameter logic [SEL_W-1:0] SEL_CODE = 16'hFF10,
  parameter int              EC_W     = 6,
  parameter logic [EC_W-1:0] TRAP_EC  = 6'h18
) (
  input  logic             valid_i,
  input  logic [1:0]       el_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             el3_present_i,
  input  logic             ns_i,
  input  logic             sel2_en_i,
  input  logic             st_access_i,
  input  logic             off_impl_i,
  input  logic             el2_on_i,
  input  logic             off_en3_i,
  input  logic             off_en2_i,
  output outcome_e         outcome_o,
  output logic [EC_W-1:0]  trap_class_o,
  output logic             use_off_o
);
  logic off_active;
  assign off_active = off_impl_i & el2_on_i & off_en3_i & off_en2_i;

  always_comb begin
    outcome_o = OUT_OK;
    use_off_o = 1'b0;
    if (valid_i) begin
      if (sel_i != SEL_CODE) begin
        outcome_o = OUT_UNDEF;
      end else begin
        unique case (el_i)
          LVL3: outcome_o = OUT_OK;
          LVL1: begin
            if (!el3_present_i || ns_i || sel2_en_i) outcome_o = OUT_UNDEF;
            else if (!st_access_i)                   outcome_o = OUT_TRAP;
            else begin
              outcome_o = OUT_OK;
              use_off_o = off_active;
            end
          end
          default: outcome_o = OUT_UNDEF;
        endcase
      end
    end
  end

  assign trap_class_o = (outcome_o == OUT_TRAP) ? TRAP_EC : '0;
endmodule

// File: rtl/sct_cmp_reg.sv
module sct_cmp_reg #(
  parameter int CNT_W  = 64,
  parameter int VIEW_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              ena_i,
  input  logic [VIEW_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  off_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  rdata_o
);
  localparam int EXT_W = CNT_W - VIEW_W;

  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] view_sx;
  logic [CNT_W-1:0] base;

  assign view_sx = {{EXT_W{wdata_i[VIEW_W-1]}}, wdata_i};
  assign base    = count_i - off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cmp_q <= '0;
    else if (wr_en_i) cmp_q <= view_sx + base;
  end

  assign cmp_o   = cmp_q;
  assign rdata_o = (rd_en_i && ena_i) ? (cmp_q - base) : '0;

  // R8
  hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cmp_q));
  // R1
  write_relative_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cmp_q - $past(base)) == $past(view_sx));
endmodule

// File: rtl/sct_cond.sv
module sct_cond #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ena_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             cond_o
);
  logic [CNT_W-1:0] diff;
  logic             cond_q;

  assign diff = count_i - cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b0;
    else         cond_q <= ena_i & ~diff[CNT_W-1];
  end

  assign cond_o = cond_q;

  // R3
  off_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena_i |=> !cond_q);
  // R3
  not_before_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_i && (count_i + 64'd1 == cmp_i)) |=> !cond_q);
endmodule

// File: rtl/sec_cmp_timer.sv
module sec_cmp_timer
  import sct_pkg::*;
#(
  parameter int               CNT_W    = 64,
  parameter int               VIEW_W   = 32,
  parameter int               SEL_W    = 16,
  parameter logic [SEL_W-1:0] SEL_CODE = 16'hFF10,
  parameter int               EC_W     = 6,
  parameter logic [EC_W-1:0]  TRAP_EC  = 6'h18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic             el3_present_i,
  input  logic             ns_i,
  input  logic             sel2_en_i,
  input  logic             st_access_i,
  input  logic             off_impl_i,
  input  logic             el2_on_i,
  input  logic             off_en3_i,
  input  logic             off_en2_i,
  input  logic             ena_we_i,
  input  logic             ena_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [1:0]       req_el_i,
  input  logic [SEL_W-1:0] req_sel_i,
  input  logic [CNT_W-1:0] req_wdata_i,
  output logic [1:0]       outcome_o,
  output logic [EC_W-1:0]  trap_class_o,
  output logic [CNT_W-1:0] rdata_o,
  output logic             cond_o
);
  outcome_e         outcome;
  logic             use_off;
  logic             acc_ok;
  logic             ena_q;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] off_sel;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata_i[CNT_W-1:VIEW_W];

  sct_access_chk #(
    .SEL_W(SEL_W), .SEL_CODE(SEL_CODE), .EC_W(EC_W), .TRAP_EC(TRAP_EC)
  ) u_chk (
    .valid_i      (req_valid_i),
    .el_i         (req_el_i),
    .sel_i        (req_sel_i),
    .el3_present_i(el3_present_i),
    .ns_i         (ns_i),
    .sel2_en_i    (sel2_en_i),
    .st_access_i  (st_access_i),
    .off_impl_i   (off_impl_i),
    .el2_on_i     (el2_on_i),
    .off_en3_i    (off_en3_i),
    .off_en2_i    (off_en2_i),
    .outcome_o    (outcome),
    .trap_class_o (trap_class_o),
    .use_off_o    (use_off)
  );

  assign acc_ok  = req_valid_i && (outcome == OUT_OK);
  assign off_sel = use_off ? offset_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ena_q <= 1'b0;
    else if (ena_we_i) ena_q <= ena_i;
  end

  sct_cmp_reg #(.CNT_W(CNT_W), .VIEW_W(VIEW_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(acc_ok && req_write_i),
    .rd_en_i(acc_ok && !req_write_i),
    .ena_i  (ena_q),
    .wdata_i(req_wdata_i[VIEW_W-1:0]),
    .count_i(count_i),
    .off_i  (off_sel),
    .cmp_o  (cmp),
    .rdata_o(rdata_o)
  );

  sct_cond #(.CNT_W(CNT_W)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ena_i  (ena_q),
    .count_i(count_i),
    .cmp_i  (cmp),
    .cond_o (cond_o)
  );

  assign outcome_o = outcome;

  // R5
  low_levels_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_el_i == LVL0 || req_el_i == LVL2)) |-> outcome_o == OUT_UNDEF);
  // R7
  trap_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outcome_o == OUT_TRAP) == (trap_class_o == TRAP_EC));
  // R8
  reject_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outcome_o != OUT_OK) |-> rdata_o == '0);
  // R5
  outcome_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(outcome_o));
  // R4
  el3_no_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_el_i == LVL3) |-> !use_off);
endmodule

// File: tb/sim_sec_cmp_timer.sv
module sim_sec_cmp_timer;
  localparam logic [15:0] SEL = 16'hFF10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0, offv = '0, wdata = '0;
  logic        pres = 1, ns = 0, s2 = 0, st = 1, fi = 0, e2on = 0, oe3 = 0, oe2 = 0;
  logic        ena_we = 0, ena_d = 0, valid = 0, wr = 0;
  logic [1:0]  el = 2'd3;
  logic [15:0] sel = SEL;
  logic [1:0]  outcome;
  logic [5:0]  tclass;
  logic [63:0] rdata;
  logic        cond;

  int n_tests = 0, n_fail = 0;
  logic [63:0] cmp_m = '0;
  logic        en_m = 0, exp_cond = 0;

  always #10 clk = ~clk;

  sec_cmp_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .offset_i(offv),
    .el3_present_i(pres), .ns_i(ns), .sel2_en_i(s2), .st_access_i(st),
    .off_impl_i(fi), .el2_on_i(e2on), .off_en3_i(oe3), .off_en2_i(oe2),
    .ena_we_i(ena_we), .ena_i(ena_d), .req_valid_i(valid), .req_write_i(wr),
    .req_el_i(el), .req_sel_i(sel), .req_wdata_i(wdata),
    .outcome_o(outcome), .trap_class_o(tclass), .rdata_o(rdata), .cond_o(cond));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] f_out();
    if (!valid) return 2'b00;
    if (sel != SEL) return 2'b01;
    if (el == 2'd3) return 2'b00;
    if (el != 2'd1) return 2'b01;
    if (!pres || ns || s2) return 2'b01;
    if (!st) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [63:0] f_off();
    return (el == 2'd1 && fi && e2on && oe3 && oe2) ? offv : 64'd0;
  endfunction

  // check this cycle's combinational outputs and the registered condition, then clock once
  task automatic cycle();
    logic [1:0]  eo;
    logic [63:0] er, d;
    logic        nc;
    #2;
    eo = f_out();
    chk(outcome == eo, (el == 2'd1) ? "R6/R7 outcome" : "R5 outcome", {62'd0, outcome}, {62'd0, eo});
    chk(tclass == ((eo == 2'b10) ? 6'h18 : 6'h0), "R7 class", {58'd0, tclass}, (eo == 2'b10) ? 64'h18 : 64'h0);
    er = (valid && !wr && eo == 2'b00 && en_m) ? cmp_m - (cnt - f_off()) : 64'd0;
    chk(rdata == er, (eo != 2'b00) ? "R8 rdata" : (f_off() != 0 ? "R4 rdata" : "R2 rdata"), rdata, er);
    chk(cond == exp_cond, "R3 cond", {63'd0, cond}, {63'd0, exp_cond});
    d  = cnt - cmp_m;
    nc = en_m && !d[63];
    if (valid && wr && eo == 2'b00)
      cmp_m = {{32{wdata[31]}}, wdata[31:0]} + cnt - f_off();
    if (ena_we) en_m = ena_d;
    @(posedge clk);
    exp_cond = nc;
    @(negedge clk);
  endtask

  task automatic idle();
    valid = 0; wr = 0; ena_we = 0;
  endtask

  task automatic acc(input bit w, input logic [1:0] l, input logic [63:0] data);
    valid = 1; wr = w; el = l; sel = SEL; wdata = data; ena_we = 0;
    cycle();
    idle();
  endtask

  task automatic set_en(input bit v);
    idle(); ena_we = 1; ena_d = v;
    cycle();
    ena_we = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [63:0] s;
    s = {32'd0, $urandom(32'd1234)};
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(cond == 1'b0, "R9 cond reset", {63'd0, cond}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    cycle();
    acc(0, 2'd3, 0);                       // R2: disabled read gives 0
    set_en(1);                             // R10
    cnt = 64'd77;
    acc(0, 2'd3, 0);                       // R9: cmp 0 -> read 0 - 77
    // R1: negative write, upper bits ignored
    cnt = 64'd1000;
    acc(1, 2'd3, 64'hDEAD_BEEF_FFFF_FFFF);
    chk(cmp_m == 64'd999, "R1 model", cmp_m, 64'd999);
    acc(0, 2'd3, 0);
    cycle(); cycle();                      // R3: cond asserted
    // R3/R1: wrap of 64-bit count
    cnt = 64'hFFFF_FFFF_FFFF_FFF0;
    acc(1, 2'd3, 64'h20);
    cycle();
    cnt = 64'hFFFF_FFFF_FFFF_FFFF; cycle();
    cnt = 64'd15; cycle();
    cnt = 64'd16; cycle(); cycle();
    // R4: offset path
    fi = 1; e2on = 1; oe3 = 1; oe2 = 1; offv = 64'd500;
    cnt = 64'd4000;
    acc(1, 2'd1, 64'd100);
    acc(0, 2'd1, 0);
    acc(0, 2'd3, 0);
    // R10: disable
    set_en(0); cycle();
    set_en(1);
    // R5/R6/R7: all level and security combinations
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < 16; c++) begin
        pres = c[0]; ns = c[1]; s2 = c[2]; st = c[3];
        acc(1, l[1:0], {32'd0, $urandom()});
        acc(0, l[1:0], 0);
      end
    sel = 16'hFF11; valid = 1; wr = 1; el = 2'd3; cycle(); idle();   // R5 selector
    // random mix
    for (int i = 0; i < 3000; i++) begin
      el    = 2'($urandom());
      pres  = ($urandom() % 8) != 0;
      ns    = ($urandom() % 4) == 0;
      s2    = ($urandom() % 4) == 0;
      st    = ($urandom() % 4) != 0;
      fi    = $urandom(); e2on = $urandom(); oe3 = $urandom(); oe2 = $urandom();
      offv  = {$urandom(), $urandom()};
      valid = ($urandom() % 3) != 0;
      wr    = $urandom();
      sel   = (($urandom() % 8) == 0) ? 16'($urandom()) : SEL;
      wdata = {$urandom(), 26'd0, 6'($urandom())};
      if ($urandom() % 2) wdata[31:0] = -wdata[31:0];
      ena_we = ($urandom() % 16) == 0;
      ena_d  = ($urandom() % 4) != 0;
      if (($urandom() % 64) == 0) cnt = {$urandom(), $urandom()};
      else cnt = cnt + 64'($urandom() % 8);
      cycle();
    end
    finish_run();
  end
endmodule